// File: doc/BRIEF.md
# Programmable period and duty-cycle PWM generator

The block produces one pulse-width modulated output from its input clock. An 8-bit period value F and an 8-bit high-time value P set the waveform. A clock-divide bit CD can halve the internal count rate, which doubles both lengths. Each output period starts high, stays high for (P+1)(CD+1) input clocks, and is low for the rest of the (F+1)(CD+1) clocks.

Settings arrive as a commit strobe with a flag that marks the commit as full or partial.
- A full commit carries F, P, CD and a power-down bit.
- A partial commit carries F and P only.

While the generator runs, committed values wait in a shadow buffer and are loaded at the next period boundary.

The output stays low after reset, and while power-down is set, until a full commit arrives with power-down clear. A digital over-threshold flag is resynchronised to the clock. Once it is seen, the output is forced low and held low until the flag clears and a new commit arrives. All output transitions are taken on the falling edge of the input clock.

Top module: `pwm_gen`

## Requirements
- R1: While running, the output period is (F+1)(CD+1) input clock cycles.
- R2: Each period begins high, stays high for (P+1)(CD+1) cycles, and is low for the remaining cycles (for example CD=0, F=4, P=1 gives 2 high and 3 low; F=5, P=3 gives 4 high and 2 low).
- R3: When P is greater than or equal to F, the output stays high for the entire period and shows no low phase.
- R4: With CD=1 the period and high counts advance on every second input clock, so CD=1, F=4, P=1 gives 4 high and 6 low.
- R5: A commit made while running does not change the period in progress. The new values take effect from the next period boundary.
- R6: After reset the output is low, and partial commits are ignored until the first full commit with power-down clear.
- R7: Once the synchronised over-threshold flag is high, the output is low within three input clocks of the flag rising. While the flag stays high, the output stays low.
- R8: After a trip, the output stays low after the flag clears until a new commit. Commits made while the flag is high are dropped. A partial release commit keeps the previous CD.
- R9: A full commit with power-down set forces the output low at once. Partial commits are then ignored, and only a full commit with power-down clear restarts the output.
- R10: The output changes only on the falling edge of the input clock. A commit that starts the generator produces a high output at the first falling edge after the commit is sampled.
- R11: The over-threshold input passes through a two-flop synchroniser. The output still follows the programmed waveform for the first two rising edges after the flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be modulated |
| rst_ni | input | 1 | Active-low asynchronous reset |
| commit_i | input | 1 | One-cycle strobe that commits new settings |
| full_i | input | 1 | Marks the commit as full (F, P, CD, power-down) rather than partial (F, P) |
| freq_i | input | 8 | Period value F |
| pw_i | input | 8 | High-time value P |
| cd_i | input | 1 | Clock-divide bit, 1 halves the count rate (full commits only) |
| pd_i | input | 1 | Power-down bit, 1 stops counting (full commits only) |
| over_thr_i | input | 1 | Asynchronous over-threshold flag |
| pwm_o | output | 1 | Modulated output |

## Verification
The waveform is checked against the high and low lengths of each complete period. The patterns used are:
- CD=0 with two F/P pairs, which separates the period formula from the high-time formula.
- CD=1, which shows whether the prescaler scales both lengths.
- P at and above F, which tests the case with no low phase.

A partial commit placed early in the high phase of a long period shows whether the shadow buffer holds the new values back until the boundary. The trip and power-down sequences each send commits that must be dropped and confirm that the output stays low. They then release with a partial or a full commit and check the waveform that follows, including the CD value kept across a partial release. The synchroniser latency is measured on an output that is constantly high, so the cycle in which it drops can be seen exactly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,  // unprogrammed or powered down
    ST_RUN  = 2'd1,
    ST_TRIP = 2'd2   // forced low by threshold
  } pwm_state_e;
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= 1'b0;
        else         sr_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= 1'b0;
        else         sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         restart_i,
  input  logic         cd_i,
  input  logic [W-1:0] freq_i,
  input  logic [W-1:0] pw_i,
  output logic         bound_o,
  output logic         high_o
);
  logic         presc_q;
  logic [W-1:0] cnt_q;
  logic         tick;
  logic         last;

  assign tick = ~cd_i | presc_q;
  assign last = (cnt_q == freq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= 1'b0;
      cnt_q   <= '0;
    end else if (restart_i) begin
      presc_q <= 1'b0;
      cnt_q   <= '0;
    end else if (run_i) begin
      presc_q <= cd_i ? ~presc_q : 1'b0;
      if (tick) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign bound_o = run_i & tick & last;
  // covers P >= F: whole period high
  assign high_o  = (cnt_q <= pw_i);

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= freq_i));

  p_presc_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cd_i |-> !presc_q);

  p_half_rate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cd_i && !presc_q && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         commit_i,
  input  logic         full_i,
  input  logic [W-1:0] freq_i,
  input  logic [W-1:0] pw_i,
  input  logic         cd_i,
  input  logic         pd_i,
  input  logic         thr_i,
  input  logic         bound_i,
  output pwm_state_e   state_o,
  output logic         restart_o,
  output logic [W-1:0] freq_o,
  output logic [W-1:0] pw_o,
  output logic         cd_o
);
  pwm_state_e   state_q, nxt_state;
  logic [W-1:0] act_f_q, act_p_q, pend_f_q, pend_p_q;
  logic [W-1:0] nxt_act_f, nxt_act_p, nxt_pend_f, nxt_pend_p;
  logic         act_cd_q, pend_cd_q, pend_v_q;
  logic         nxt_act_cd, nxt_pend_cd, nxt_pend_v;
  logic         commit_ok, full_on, full_off, src_cd;

  assign commit_ok = commit_i & ~thr_i;
  assign full_on   = commit_ok & full_i & ~pd_i;
  assign full_off  = commit_ok & full_i & pd_i;
  assign src_cd    = full_i ? cd_i : (pend_v_q ? pend_cd_q : act_cd_q);

  always_comb begin
    nxt_state   = state_q;
    nxt_act_f   = act_f_q;
    nxt_act_p   = act_p_q;
    nxt_act_cd  = act_cd_q;
    nxt_pend_f  = pend_f_q;
    nxt_pend_p  = pend_p_q;
    nxt_pend_cd = pend_cd_q;
    nxt_pend_v  = pend_v_q;
    restart_o   = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (full_on) begin
          nxt_state  = ST_RUN;
          restart_o  = 1'b1;
          nxt_act_f  = freq_i;
          nxt_act_p  = pw_i;
          nxt_act_cd = cd_i;
          nxt_pend_v = 1'b0;
        end
      end
      ST_RUN: begin
        if (thr_i) begin
          nxt_state  = ST_TRIP;
          nxt_pend_v = 1'b0;
        end else if (full_off) begin
          nxt_state  = ST_OFF;
          nxt_pend_v = 1'b0;
        end else begin
          if (commit_ok) begin
            nxt_pend_f  = freq_i;
            nxt_pend_p  = pw_i;
            nxt_pend_cd = src_cd;
            nxt_pend_v  = 1'b1;
          end
          // shadow reaches active set only at the period boundary
          if (bound_i && (commit_ok || pend_v_q)) begin
            nxt_act_f  = commit_ok ? freq_i : pend_f_q;
            nxt_act_p  = commit_ok ? pw_i   : pend_p_q;
            nxt_act_cd = commit_ok ? src_cd : pend_cd_q;
            nxt_pend_v = 1'b0;
          end
        end
      end
      ST_TRIP: begin
        if (full_off) begin
          nxt_state = ST_OFF;
        end else if (commit_ok) begin
          nxt_state  = ST_RUN;
          restart_o  = 1'b1;
          nxt_act_f  = freq_i;
          nxt_act_p  = pw_i;
          nxt_act_cd = full_i ? cd_i : act_cd_q;
        end
      end
      default: nxt_state = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      act_f_q   <= '0;
      act_p_q   <= '0;
      act_cd_q  <= 1'b0;
      pend_f_q  <= '0;
      pend_p_q  <= '0;
      pend_cd_q <= 1'b0;
      pend_v_q  <= 1'b0;
    end else begin
      state_q   <= nxt_state;
      act_f_q   <= nxt_act_f;
      act_p_q   <= nxt_act_p;
      act_cd_q  <= nxt_act_cd;
      pend_f_q  <= nxt_pend_f;
      pend_p_q  <= nxt_pend_p;
      pend_cd_q <= nxt_pend_cd;
      pend_v_q  <= nxt_pend_v;
    end
  end

  assign state_o = state_q;
  assign freq_o  = act_f_q;
  assign pw_o    = act_p_q;
  assign cd_o    = act_cd_q;

  p_hold_shadow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !bound_i) |=>
      ($stable(act_f_q) && $stable(act_p_q) && $stable(act_cd_q)));

  p_off_stays_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && !(commit_i && full_i && !pd_i && !thr_i)) |=>
      (state_q == ST_OFF));

  p_trip_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && thr_i) |=> (state_q == ST_TRIP));

  p_trip_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRIP && !commit_i) |=> (state_q == ST_TRIP));

  p_pd_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && commit_i && !full_i) |=> (state_q == ST_OFF));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         commit_i,
  input  logic         full_i,
  input  logic [W-1:0] freq_i,
  input  logic [W-1:0] pw_i,
  input  logic         cd_i,
  input  logic         pd_i,
  input  logic         over_thr_i,
  output logic         pwm_o
);
  logic         thr_s;
  pwm_state_e   state;
  logic         restart, bound, high;
  logic [W-1:0] act_f, act_p;
  logic         act_cd;
  logic         run;
  logic         pwm_q;

  pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (over_thr_i),
    .q_o   (thr_s)
  );

  pwm_ctrl #(.W(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_i),
    .full_i   (full_i),
    .freq_i   (freq_i),
    .pw_i     (pw_i),
    .cd_i     (cd_i),
    .pd_i     (pd_i),
    .thr_i    (thr_s),
    .bound_i  (bound),
    .state_o  (state),
    .restart_o(restart),
    .freq_o   (act_f),
    .pw_o     (act_p),
    .cd_o     (act_cd)
  );

  assign run = (state == ST_RUN);

  pwm_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .restart_i(restart),
    .cd_i     (act_cd),
    .freq_i   (act_f),
    .pw_i     (act_p),
    .bound_o  (bound),
    .high_o   (high)
  );

  // output retimed to the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= run & high & ~thr_s;
  end

  assign pwm_o = pwm_q;

  p_trip_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_s |-> !pwm_o);

  p_off_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_RUN) |-> !pwm_o);

  p_start_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !thr_s) |=> pwm_o);
endmodule

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       commit_i = 1'b0, full_i = 1'b0, cd_i = 1'b0, pd_i = 1'b0;
  logic       over_thr_i = 1'b0;
  logic [7:0] freq_i = '0, pw_i = '0;
  logic       pwm_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit mon_sync = 0;

  int    exp_hi[$];
  int    exp_lo[$];
  string exp_tag[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  pwm_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit_i), .full_i(full_i),
    .freq_i(freq_i), .pw_i(pw_i), .cd_i(cd_i), .pd_i(pd_i),
    .over_thr_i(over_thr_i), .pwm_o(pwm_o)
  );

  task automatic chk(bit ok, string req, string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic int hi_len(int f, int p, int cd);
    return (p + 1) * (cd + 1);
  endfunction
  function automatic int lo_len(int f, int p, int cd);
    return (f - p) * (cd + 1);
  endfunction

  task automatic do_commit(bit full, int f, int p, bit cd, bit pd);
    @(negedge clk_i);
    full_i = full; freq_i = 8'(f); pw_i = 8'(p); cd_i = cd; pd_i = pd;
    commit_i = 1'b1;
    @(negedge clk_i);
    commit_i = 1'b0;
  endtask

  task automatic push(int f, int p, int cd, string tag, int n);
    for (int i = 0; i < n; i++) begin
      exp_hi.push_back(hi_len(f, p, cd));
      exp_lo.push_back(lo_len(f, p, cd));
      exp_tag.push_back(tag);
    end
  endtask

  task automatic settle();
    repeat (50) @(posedge clk_i);
    mon_sync = 1;
    @(posedge clk_i);
  endtask

  task automatic drain(string tag);
    int t = 0;
    while (exp_hi.size() > 0 && t < 3000) begin
      @(posedge clk_i);
      t++;
    end
    if (exp_hi.size() > 0) begin
      chk(0, tag, $sformatf("pending periods actual=%0d expected=0", exp_hi.size()));
      exp_hi.delete(); exp_lo.delete(); exp_tag.delete();
    end
  endtask

  task automatic hold_level(bit lvl, int n, string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      if (pwm_o !== lvl) bad++;
    end
    chk(bad == 0, tag, $sformatf("cycles off level actual=%0d expected=0 (level %0d)", bad, lvl));
  endtask

  task automatic sample_is(bit lvl, string tag);
    @(posedge clk_i); #1;
    chk(pwm_o === lvl, tag, $sformatf("pwm_o actual=%0b expected=%0b", pwm_o, lvl));
  endtask

  // monitor: measure rise-to-rise periods and compare with scoreboard
  initial begin
    bit prev = 0, have = 0;
    int hi = 0, lo = 0;
    forever begin
      @(posedge clk_i); #1;
      if (mon_sync) begin
        have = 0; mon_sync = 0;
      end else if (pwm_o && !prev) begin
        if (have && exp_hi.size() > 0) begin
          int eh, el;
          string tg;
          eh = exp_hi.pop_front(); el = exp_lo.pop_front(); tg = exp_tag.pop_front();
          chk(hi == eh && lo == el, tg,
              $sformatf("high/low actual=%0d/%0d expected=%0d/%0d", hi, lo, eh, el));
        end
        have = 1; hi = 1; lo = 0;
      end else if (pwm_o) hi++;
      else lo++;
      prev = pwm_o;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(pwm_o === 1'b0, "R6", $sformatf("reset pwm_o actual=%0b expected=0", pwm_o));
    rst_ni = 1'b1;
    // R6: partial commit before first full one is ignored
    do_commit(0, 4, 1, 0, 0);
    hold_level(0, 30, "R6");

    // R10: first full commit starts high; R1/R2 basic waveform
    do_commit(1, 4, 1, 0, 0);
    sample_is(1, "R10");
    settle();
    push(4, 1, 0, "R2", 3);
    drain("R2");
    do_commit(0, 5, 3, 0, 0);
    settle();
    push(5, 3, 0, "R1", 3);
    drain("R1");

    // R4: divide by two
    do_commit(1, 4, 1, 1, 0);
    settle();
    push(4, 1, 1, "R4", 2);
    drain("R4");

    // R5: commit in middle of high phase applies at boundary
    do_commit(1, 9, 5, 0, 0);
    settle();
    begin
      bit pv, rose;
      pv = pwm_o;
      do begin
        @(posedge clk_i); #1;
        rose = pwm_o && !pv;
        pv = pwm_o;
      end while (!rose);
    end
    do_commit(0, 4, 1, 0, 0);
    push(9, 5, 0, "R5", 1);
    push(4, 1, 0, "R5", 2);
    drain("R5");

    // R3: P above and equal to F
    do_commit(0, 3, 7, 0, 0);
    repeat (20) @(posedge clk_i);
    hold_level(1, 40, "R3");
    do_commit(0, 3, 3, 0, 0);
    repeat (20) @(posedge clk_i);
    hold_level(1, 40, "R3");

    // R11: two-flop latency, then R7 forced low
    @(negedge clk_i);
    over_thr_i = 1'b1;
    sample_is(1, "R11");
    sample_is(1, "R11");
    sample_is(0, "R7");
    hold_level(0, 20, "R7");
    over_thr_i = 1'b0;
    repeat (5) @(posedge clk_i);
    do_commit(1, 4, 1, 1, 0);  // release with CD=1
    settle();
    push(4, 1, 1, "R8", 1);
    drain("R8");

    // R8: trip latch, dropped commit, partial release keeps CD=1
    @(negedge clk_i);
    over_thr_i = 1'b1;
    repeat (4) @(posedge clk_i);
    do_commit(0, 2, 0, 0, 0);
    hold_level(0, 10, "R7");
    @(negedge clk_i);
    over_thr_i = 1'b0;
    hold_level(0, 30, "R8");
    do_commit(0, 5, 3, 0, 0);
    sample_is(1, "R8");
    settle();
    push(5, 3, 1, "R8", 2);
    drain("R8");

    // R9: power down
    do_commit(1, 4, 1, 0, 1);
    hold_level(0, 30, "R9");
    do_commit(0, 4, 1, 0, 0);
    hold_level(0, 30, "R9");
    do_commit(1, 4, 1, 0, 0);
    sample_is(1, "R9");
    settle();
    push(4, 1, 0, "R9", 2);
    drain("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule